// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm Compare

This block keeps a 24-hour time of day as separate hour, minute and second fields. A single-cycle pulse once per second steps it forward. It also holds an alarm time. When a tick brings the running time onto a legal alarm time, the block raises a sticky flag. That flag stays high until a clear input is pulsed.

Software or a bus front end loads the six fields one at a time through a small write port. Each write carries a field select code and a data byte. The two register sets handle out-of-range data differently:

- **Alarm fields** keep only the low bits of the byte. Any value is stored as written, even an illegal one, so writing a time outside the legal range is how the alarm is switched off.
- **Watch hours** above 23 are clamped to 23.

The bus interface, the source of the one-second pulse and power sequencing are outside this block.

Top module: `watch_alarm_timer`

## Requirements
- R1: After reset the watch reads 00:00:00, the alarm reads 31:63:63, `alarm_valid` is 0 and `alarm_flag` is 0.
- R2: A `tick_1hz` pulse advances the seconds by one on the next clock edge. Seconds at 59 return to 0 and advance the minutes.
- R3: Minutes at 59 return to 0 when a carry arrives, and advance the hours. Hours at 23 return to 0 when a carry arrives.
- R4: A minute or second value of 60 to 63 behaves like 59 on a tick or carry: it becomes 0 and passes a carry on.
- R5: Writes to the alarm fields store the data unlimited, masked to its low bits: hours keep `wr_data[4:0]`, minutes and seconds keep `wr_data[5:0]`. The `wr_sel` codes are 0 for hours, 1 for minutes and 2 for seconds.
- R6: Writes to the watch fields use `wr_sel` 3 for hours, 4 for minutes and 5 for seconds.
  - Hours take `wr_data[4:0]`, clamped to 23 when larger.
  - Minutes and seconds take `wr_data[5:0]`.
  - Watch hours never exceed 23.
- R7: `alarm_valid` is 1 exactly when the alarm hours are at most 23, and the alarm minutes and alarm seconds are each at most 59.
- R8: `alarm_flag` goes to 1 one clock after the edge where a tick moves the watch onto a time equal to a valid alarm. A write that makes the two equal does not set it.
- R9: `alarm_flag` stays at 1 until `alarm_clr` is sampled high. When a set and a clear land in the same cycle, the set wins.
- R10: A watch-field write in the same cycle as a tick replaces that field's increment. The other fields still advance using the carries from the old values.
- R11: A write with `wr_sel` of 6 or 7 changes no watch or alarm field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Field select code for the write |
| wr_data | input | 8 | Write data byte |
| alarm_clr | input | 1 | Clears the alarm flag |
| watch_hh | output | 5 | Watch hours |
| watch_mm | output | 6 | Watch minutes |
| watch_ss | output | 6 | Watch seconds |
| alarm_hh | output | 5 | Alarm hours |
| alarm_mm | output | 6 | Alarm minutes |
| alarm_ss | output | 6 | Alarm seconds |
| alarm_valid | output | 1 | Alarm time is within legal range |
| alarm_flag | output | 1 | Sticky alarm event |

## Verification
Results are due at these edges:

- **Field writes** show on the outputs at the first clock edge that samples the write.
- **Ticks** update the watch fields at the first edge that samples the tick.
- **The alarm flag** follows one edge later, because the tick is registered before the compare.

The bench drives inputs on falling edges. It reads watch fields and `alarm_valid` at the falling edge after the sampling edge, and reads the flag one full cycle later. The bench sweeps every data byte through each field, and steps the watch tick by tick across midnight against an arithmetic seconds-of-day model.

// File: rtl/wt_pkg.sv
// Shared definitions for the time-of-day counter.
// Assumes a 3-bit field select on the write port.
package wt_pkg;
    typedef enum logic [2:0] {
        FLD_ALM_HH = 3'd0,
        FLD_ALM_MM = 3'd1,
        FLD_ALM_SS = 3'd2,
        FLD_WCH_HH = 3'd3,
        FLD_WCH_MM = 3'd4,
        FLD_WCH_SS = 3'd5
    } fld_sel_e;

    localparam int NUM_FIELDS = 6;
endpackage

// File: rtl/wt_watch_ctr.sv
// Running hour/minute/second counter stepped by a one-cycle tick.
// Assumes tick is a single-cycle pulse. A write strobe to a field overrides
// that field's step. Carries are formed from the pre-update values.
module wt_watch_ctr #(
    parameter int HR_W    = 5,
    parameter int MS_W    = 6,
    parameter int HR_LAST = 23,
    parameter int MS_LAST = 59
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            wr_hh,
    input  logic            wr_mm,
    input  logic            wr_ss,
    input  logic [MS_W-1:0] wr_val,
    output logic [HR_W-1:0] hh,
    output logic [MS_W-1:0] mm,
    output logic [MS_W-1:0] ss
);
    localparam logic [HR_W-1:0] HR_LIM = HR_W'(HR_LAST);
    localparam logic [MS_W-1:0] MS_LIM = MS_W'(MS_LAST);

    logic            ss_wrap, mm_wrap, hh_wrap;
    logic            mm_step, hh_step;
    logic [HR_W-1:0] hh_load;

    // Carry chain: values at or above the last legal value roll over.
    always_comb begin
        ss_wrap = (ss >= MS_LIM);
        mm_wrap = (mm >= MS_LIM);
        hh_wrap = (hh >= HR_LIM);
        mm_step = tick && ss_wrap;
        hh_step = mm_step && mm_wrap;
        hh_load = (wr_val[HR_W-1:0] > HR_LIM) ? HR_LIM : wr_val[HR_W-1:0];
    end

    // Seconds register: write first, then tick step.
    always_ff @(posedge clk) begin
        if (!rst_n)       ss <= '0;
        else if (wr_ss)   ss <= wr_val;
        else if (tick)    ss <= ss_wrap ? '0 : ss + 1'b1;
    end

    // Minutes register: write first, then carry from seconds.
    always_ff @(posedge clk) begin
        if (!rst_n)       mm <= '0;
        else if (wr_mm)   mm <= wr_val;
        else if (mm_step) mm <= mm_wrap ? '0 : mm + 1'b1;
    end

    // Hours register: clamped write first, then carry from minutes.
    always_ff @(posedge clk) begin
        if (!rst_n)       hh <= '0;
        else if (wr_hh)   hh <= hh_load;
        else if (hh_step) hh <= hh_wrap ? '0 : hh + 1'b1;
    end
endmodule

// File: rtl/wt_alarm_regs.sv
// Alarm time storage with a legality flag.
// Assumes masking has been done by the caller's slicing; values are
// stored without limiting, and an illegal time marks the alarm invalid.
module wt_alarm_regs #(
    parameter int HR_W    = 5,
    parameter int MS_W    = 6,
    parameter int HR_LAST = 23,
    parameter int MS_LAST = 59
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hh,
    input  logic            wr_mm,
    input  logic            wr_ss,
    input  logic [MS_W-1:0] wr_val,
    output logic [HR_W-1:0] hh,
    output logic [MS_W-1:0] mm,
    output logic [MS_W-1:0] ss,
    output logic            valid
);
    localparam logic [HR_W-1:0] HR_LIM = HR_W'(HR_LAST);
    localparam logic [MS_W-1:0] MS_LIM = MS_W'(MS_LAST);

    // Field storage; reset to all ones, which is an illegal (disabled) time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hh <= '1;
            mm <= '1;
            ss <= '1;
        end else begin
            if (wr_hh) hh <= wr_val[HR_W-1:0];
            if (wr_mm) mm <= wr_val;
            if (wr_ss) ss <= wr_val;
        end
    end

    // Legality check of the stored alarm time.
    always_comb valid = (hh <= HR_LIM) && (mm <= MS_LIM) && (ss <= MS_LIM);
endmodule

// File: rtl/wt_alarm_match.sv
// Sticky alarm event flag.
// Assumes the watch fields settle on the edge that samples the tick; the
// compare runs one cycle later. Set outranks clear.
module wt_alarm_match #(
    parameter int HR_W = 5,
    parameter int MS_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            clr,
    input  logic [HR_W-1:0] w_hh,
    input  logic [MS_W-1:0] w_mm,
    input  logic [MS_W-1:0] w_ss,
    input  logic [HR_W-1:0] a_hh,
    input  logic [MS_W-1:0] a_mm,
    input  logic [MS_W-1:0] a_ss,
    input  logic            a_valid,
    output logic            flag
);
    logic tick_q;
    logic hit;

    // Delay the tick so the compare sees the freshly stepped watch.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick;
    end

    // Match detect on the cycle after a tick.
    always_comb hit = tick_q && a_valid && (w_hh == a_hh) && (w_mm == a_mm) && (w_ss == a_ss);

    // Sticky flag with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/watch_alarm_timer.sv
// Top level: decodes the field write port, then instantiates the watch
// counter, the alarm registers and the match flag.
// Assumes DATA_W > MS_W >= HR_W.
module watch_alarm_timer #(
    parameter int DATA_W  = 8,
    parameter int HR_W    = 5,
    parameter int MS_W    = 6,
    parameter int HR_LAST = 23,
    parameter int MS_LAST = 59
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              alarm_clr,
    output logic [HR_W-1:0]   watch_hh,
    output logic [MS_W-1:0]   watch_mm,
    output logic [MS_W-1:0]   watch_ss,
    output logic [HR_W-1:0]   alarm_hh,
    output logic [MS_W-1:0]   alarm_mm,
    output logic [MS_W-1:0]   alarm_ss,
    output logic              alarm_valid,
    output logic              alarm_flag
);
    import wt_pkg::*;

    logic [NUM_FIELDS-1:0] strobe;
    logic [MS_W-1:0]       wr_val;
    logic                  unused_hi;

    // One strobe per field code; codes past the last field decode to nothing.
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
        assign strobe[i] = wr_en && (wr_sel == 3'(i));
    end

    // Keep only the widest field's bits of the data byte.
    assign wr_val    = wr_data[MS_W-1:0];
    assign unused_hi = ^wr_data[DATA_W-1:MS_W];

    wt_watch_ctr #(
        .HR_W(HR_W), .MS_W(MS_W), .HR_LAST(HR_LAST), .MS_LAST(MS_LAST)
    ) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1hz),
        .wr_hh  (strobe[FLD_WCH_HH]),
        .wr_mm  (strobe[FLD_WCH_MM]),
        .wr_ss  (strobe[FLD_WCH_SS]),
        .wr_val (wr_val),
        .hh     (watch_hh),
        .mm     (watch_mm),
        .ss     (watch_ss)
    );

    wt_alarm_regs #(
        .HR_W(HR_W), .MS_W(MS_W), .HR_LAST(HR_LAST), .MS_LAST(MS_LAST)
    ) u_alarm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hh  (strobe[FLD_ALM_HH]),
        .wr_mm  (strobe[FLD_ALM_MM]),
        .wr_ss  (strobe[FLD_ALM_SS]),
        .wr_val (wr_val),
        .hh     (alarm_hh),
        .mm     (alarm_mm),
        .ss     (alarm_ss),
        .valid  (alarm_valid)
    );

    wt_alarm_match #(
        .HR_W(HR_W), .MS_W(MS_W)
    ) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .clr     (alarm_clr),
        .w_hh    (watch_hh),
        .w_mm    (watch_mm),
        .w_ss    (watch_ss),
        .a_hh    (alarm_hh),
        .a_mm    (alarm_mm),
        .a_ss    (alarm_ss),
        .a_valid (alarm_valid),
        .flag    (alarm_flag)
    );
endmodule

// File: rtl/wt_checker.sv
// Temporal checks on the time-of-day counter ports.
// Attached to every instance of the top by the bind below.
// Parameter defaults must match the top's.
module wt_checker #(
    parameter int HR_W    = 5,
    parameter int MS_W    = 6,
    parameter int HR_LAST = 23,
    parameter int MS_LAST = 59
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick_1hz,
    input logic            wr_en,
    input logic [2:0]      wr_sel,
    input logic            alarm_clr,
    input logic [HR_W-1:0] watch_hh,
    input logic [MS_W-1:0] watch_ss,
    input logic [HR_W-1:0] alarm_hh,
    input logic [MS_W-1:0] alarm_mm,
    input logic [MS_W-1:0] alarm_ss,
    input logic            alarm_valid,
    input logic            alarm_flag
);
    localparam logic [HR_W-1:0] HR_LIM = HR_W'(HR_LAST);
    localparam logic [MS_W-1:0] MS_LIM = MS_W'(MS_LAST);

    // R6: watch hours never leave the legal range.
    assert_hours_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        watch_hh <= HR_LIM);

    // R2: a tick with no write moves a sub-59 second count up by one.
    assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !wr_en && watch_ss < MS_LIM) |=> (watch_ss == $past(watch_ss) + 1'b1));

    // R2: with no tick and no write, the seconds hold.
    assert_sec_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !wr_en) |=> $stable(watch_ss));

    // R5: alarm fields change only on a write.
    assert_alarm_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({alarm_hh, alarm_mm, alarm_ss}));

    // R11: an unused select code leaves the alarm and the watch hours untouched.
    assert_unused_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel > 3'd5 && !tick_1hz) |=> ($stable({alarm_hh, alarm_mm, alarm_ss}) && $stable(watch_hh)));

    // R8: the flag can only rise after a cycle with a legal alarm time.
    assert_flag_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(alarm_valid));

    // R9: once set, the flag holds until a clear is sampled.
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !alarm_clr) |=> alarm_flag);
endmodule

bind watch_alarm_timer wt_checker u_chk (.*);

// File: tb/tb_watch_alarm_timer.sv
// Self-checking bench: sweeps of every write byte, and a tick-by-tick walk
// across midnight against a seconds-of-day model.
module tb_watch_alarm_timer;
    localparam int CLK_PERIOD = 10;
    localparam int DAY = 86400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       alarm_clr = 1'b0;
    logic [4:0] watch_hh, alarm_hh;
    logic [5:0] watch_mm, watch_ss, alarm_mm, alarm_ss;
    logic       alarm_valid, alarm_flag;

    int vec = 0;
    int bad = 0;

    watch_alarm_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .alarm_clr(alarm_clr),
        .watch_hh(watch_hh), .watch_mm(watch_mm), .watch_ss(watch_ss),
        .alarm_hh(alarm_hh), .alarm_mm(alarm_mm), .alarm_ss(alarm_ss),
        .alarm_valid(alarm_valid), .alarm_flag(alarm_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One write, visible at the falling edge after the sampling edge.
    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One tick, then one extra cycle so the flag has also settled.
    task automatic tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk); alarm_clr = 1'b1;
        @(negedge clk); alarm_clr = 1'b0;
    endtask

    task automatic set_watch(input int h, input int m, input int s);
        wr(3, h); wr(4, m); wr(5, s);
    endtask

    task automatic set_alarm(input int h, input int m, input int s);
        wr(0, h); wr(1, m); wr(2, s);
    endtask

    task automatic chk_watch(input string tag, input int h, input int m, input int s);
        chk({tag, " hh"}, watch_hh, h);
        chk({tag, " mm"}, watch_mm, m);
        chk({tag, " ss"}, watch_ss, s);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        int t, at, expf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_watch("R1 watch", 0, 0, 0);
        chk("R1 alarm_hh", alarm_hh, 31);
        chk("R1 alarm_mm", alarm_mm, 63);
        chk("R1 alarm_ss", alarm_ss, 63);
        chk("R1 valid", alarm_valid, 0);
        chk("R1 flag", alarm_flag, 0);

        // R5 / R7 alarm hours sweep with legal minutes and seconds
        wr(1, 0); wr(2, 0);
        for (int d = 0; d < 256; d++) begin
            wr(0, d);
            chk("R5 alarm_hh mask", alarm_hh, d % 32);
            chk("R7 valid hh", alarm_valid, int'((d % 32) <= 23));
        end
        wr(0, 0);
        for (int d = 0; d < 256; d++) begin
            wr(1, d);
            chk("R5 alarm_mm mask", alarm_mm, d % 64);
            chk("R7 valid mm", alarm_valid, int'((d % 64) <= 59));
        end
        wr(1, 0);
        for (int d = 0; d < 256; d++) begin
            wr(2, d);
            chk("R5 alarm_ss mask", alarm_ss, d % 64);
            chk("R7 valid ss", alarm_valid, int'((d % 64) <= 59));
        end

        // R6 watch write sweeps
        for (int d = 0; d < 256; d++) begin
            wr(3, d);
            chk("R6 watch_hh clamp", watch_hh, ((d % 32) > 23) ? 23 : d % 32);
            wr(4, d);
            chk("R6 watch_mm mask", watch_mm, d % 64);
            wr(5, d);
            chk("R6 watch_ss mask", watch_ss, d % 64);
        end

        // R11 unused select codes
        set_watch(7, 8, 9);
        set_alarm(10, 11, 12);
        wr(6, 255);
        wr(7, 0);
        chk_watch("R11 watch", 7, 8, 9);
        chk("R11 alarm_hh", alarm_hh, 10);
        chk("R11 alarm_mm", alarm_mm, 11);
        chk("R11 alarm_ss", alarm_ss, 12);

        // R8 a write that makes watch equal alarm does not set the flag
        set_alarm(23, 59, 30);
        clear_flag();
        set_watch(23, 59, 30);
        @(negedge clk); @(negedge clk);
        chk("R8 write-equal no flag", alarm_flag, 0);

        // R2 / R3 / R8 / R9 tick walk across midnight
        set_watch(23, 57, 50);
        t = 23*3600 + 57*60 + 50;
        at = 23*3600 + 59*60 + 30;
        expf = 0;
        for (int k = 0; k < 200; k++) begin
            tick();
            t = (t + 1) % DAY;
            if (t == at) expf = 1;
            chk_watch("R2 R3 count", t / 3600, (t / 60) % 60, t % 60);
            chk("R8 R9 flag", alarm_flag, expf);
        end

        // R9 clear, then set and clear in the same cycle
        clear_flag();
        chk("R9 cleared", alarm_flag, 0);
        set_alarm(0, 1, 11);
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0; alarm_clr = 1'b1;
        @(negedge clk); alarm_clr = 1'b0;
        chk("R9 set beats clear", alarm_flag, 1);
        clear_flag();
        chk("R9 clear after", alarm_flag, 0);

        // R4 out-of-range minutes and seconds roll on the next tick
        set_watch(3, 5, 62);
        tick();
        chk_watch("R4 ss62", 3, 6, 0);
        set_watch(23, 61, 59);
        tick();
        chk_watch("R4 mm61 midnight", 0, 0, 0);
        set_watch(4, 63, 63);
        tick();
        chk_watch("R4 mm63 ss63", 5, 0, 0);

        // R10 write on a tick cycle overrides that field only
        set_watch(4, 10, 59);
        @(negedge clk);
        tick_1hz = 1'b1; wr_en = 1'b1; wr_sel = 3'd5; wr_data = 8'd30;
        @(negedge clk);
        tick_1hz = 1'b0; wr_en = 1'b0;
        chk_watch("R10 ss write", 4, 11, 30);
        set_watch(4, 10, 59);
        @(negedge clk);
        tick_1hz = 1'b1; wr_en = 1'b1; wr_sel = 3'd4; wr_data = 8'd20;
        @(negedge clk);
        tick_1hz = 1'b0; wr_en = 1'b0;
        chk_watch("R10 mm write", 4, 20, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule